// File: doc/BRIEF.md
# Debug Session Status Tracker

This block holds the status flags of an on-chip debug session and presents them as one read-only 8-bit status word. It follows the session's arm control and a strobe that fires each time a trace line is stored. It also takes an external tag-hit input and the state reported by the session's state sequencer, with a transition strobe and an end-by-internal-trigger strobe. It does not contain the trace memory, the comparators or the sequencer's trigger logic. It only records what those parts report.

Each flag has its own clear rule. Arming clears both sticky flags and loads state 1 into the state field. Only power-on reset clears the trace-buffer-full flag, while a system reset leaves it alone. The state field keeps its last value after a software disarm, and drops to zero when an internal trigger ends the session. A companion output gives the number of valid trace lines. This output reports the full buffer depth whenever the full flag is set, whatever the line count shows.

Top module: `dbg_status_tracker`

## Requirements
- R1: The status word carries the full flag in bit 7, the external-tag flag in bit 6 and the state field in bits 2:0. Bits 5:3 always read 0.
- R2: While armed, each cycle with `line_stored` high adds one to a count of lines since arming, which saturates at the trace depth (64). The full flag sets in the cycle the count reaches 64.
- R3: A cycle with `arm_set` high clears the full flag, the tag flag and the line count, loads state 001 into the field and sets `armed_o`. It wins over a line strobe, a tag hit, a step or a trigger end in the same cycle.
- R4: `por_n` low clears every flag and register at once. `sys_rst_n` low at a clock edge clears `armed_o`, the tag flag, the line count and the state field, and leaves the full flag unchanged.
- R5: The tag flag sets after a cycle with `ext_tag_hit` high while armed. It stays set, also through a disarm, until the next arming or reset.
- R6: While disarmed, `line_stored`, `ext_tag_hit` and `seq_step` change no flag, no count and no state.
- R7: While armed, `seq_step` loads `seq_state` into the state field if the code is 000 to 100 (0 idle, 1 to 3 states one to three, 4 final). Reserved codes 101 to 111 leave the field unchanged.
- R8: While armed, `trig_end` clears `armed_o` and sets the state field to 000. It takes priority over `seq_step`.
- R9: `arm_clr` clears `armed_o` and leaves the state field as it was, unless a step or trigger end applies in the same cycle.
- R10: `valid_lines` equals 64 while the full flag is set and equals the line count otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | Other system reset, synchronous, active low |
| arm_set | input | 1 | Write of one to the arm control |
| arm_clr | input | 1 | Software disarm |
| line_stored | input | 1 | One trace line stored this cycle |
| ext_tag_hit | input | 1 | External tag hit this cycle |
| seq_step | input | 1 | Sequencer moved to a new state |
| seq_state | input | 3 | State the sequencer moved to |
| trig_end | input | 1 | Session ended by internal trigger |
| status_word | output | 8 | Read-only status word |
| armed_o | output | 1 | Session armed |
| valid_lines | output | 7 | Number of valid trace lines |

## Verification
A wrong flag or state register shows in the status word one clock after the stimulus that went wrong, because every field is a direct register bit. An error in the line count stays hidden until the count reaches the trace depth, or until a system reset separates the count from the full flag. For that reason, long armed stretches are combined with system resets after the buffer has filled. Errors in the disarm path show only at the next step or trigger end, so strobes are driven while disarmed and checked for no effect.

// File: rtl/dst_pkg.sv
package dst_pkg;
   localparam int unsigned STATUS_W  = 8;
   localparam int unsigned FULL_BIT  = 7;
   localparam int unsigned TAG_BIT   = 6;
   localparam int unsigned SEQ_W     = 3;

   typedef enum logic [SEQ_W-1:0] {
      SEQ_IDLE  = 3'b000,
      SEQ_ONE   = 3'b001,
      SEQ_TWO   = 3'b010,
      SEQ_THREE = 3'b011,
      SEQ_FINAL = 3'b100
   } seq_state_e;

   localparam logic [SEQ_W-1:0] SEQ_LAST_LEGAL = SEQ_FINAL;
endpackage

// File: rtl/dst_line_counter.sv
module dst_line_counter #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sys_rst_n,
   input  logic             arm_set_i,
   input  logic             armed_i,
   input  logic             line_i,
   output logic             full_o,
   output logic [CNT_W-1:0] valid_o
);
   localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dst_line_counter: DEPTH must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] count_q;
   logic             full_q;
   logic             inc;

   assign inc = armed_i & line_i & (count_q < DEPTH_V);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)              count_q <= '0;
      else if (!sys_rst_n)     count_q <= '0;
      else if (arm_set_i)      count_q <= '0;
      else if (inc)            count_q <= count_q + CNT_W'(1);
   end

   // Full flag: no clear from the system reset.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) full_q <= 1'b0;
      else if (sys_rst_n) begin
         if (arm_set_i)                                  full_q <= 1'b0;
         else if (inc && (count_q == DEPTH_V - CNT_W'(1))) full_q <= 1'b1;
      end
   end

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign valid_o = full_q ? {1'b1, {(CNT_W-1){1'b0}}} : count_q;
      end else begin : g_any
         assign valid_o = full_q ? DEPTH_V : count_q;
      end
   endgenerate

   assign full_o = full_q;

   a_r2_full_at_depth: assert property (@(posedge clk) disable iff (!por_n)
      $rose(full_q) |-> (count_q == DEPTH_V));
   a_r2_count_bounded: assert property (@(posedge clk) disable iff (!por_n)
      count_q <= DEPTH_V);
   a_r4_full_kept_sysrst: assert property (@(posedge clk) disable iff (!por_n)
      !sys_rst_n |=> $stable(full_q));
endmodule

// File: rtl/dst_tag_flag.sv
module dst_tag_flag (
   input  logic clk,
   input  logic por_n,
   input  logic sys_rst_n,
   input  logic arm_set_i,
   input  logic armed_i,
   input  logic hit_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)              flag_q <= 1'b0;
      else if (!sys_rst_n)     flag_q <= 1'b0;
      else if (arm_set_i)      flag_q <= 1'b0;
      else if (armed_i && hit_i) flag_q <= 1'b1;
   end

   assign flag_o = flag_q;

   a_r5_sticky: assert property (@(posedge clk) disable iff (!por_n)
      (sys_rst_n && !arm_set_i && flag_q) |=> flag_q);
   a_r6_idle_no_set: assert property (@(posedge clk) disable iff (!por_n)
      (sys_rst_n && !armed_i && !arm_set_i && !flag_q) |=> !flag_q);
endmodule

// File: rtl/dst_state_field.sv
module dst_state_field
   import dst_pkg::*;
#(
   parameter int unsigned STATE_W = SEQ_W
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               sys_rst_n,
   input  logic               arm_set_i,
   input  logic               armed_i,
   input  logic               step_i,
   input  logic [STATE_W-1:0] next_i,
   input  logic               trig_i,
   output logic [STATE_W-1:0] state_o
);
   generate
      if (STATE_W != SEQ_W) begin : g_bad_width
         $error("dst_state_field: STATE_W must match the sequencer code width");
      end
   endgenerate

   logic [STATE_W-1:0] state_q;
   logic               legal;

   assign legal = (next_i <= SEQ_LAST_LEGAL);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                             state_q <= SEQ_IDLE;
      else if (!sys_rst_n)                    state_q <= SEQ_IDLE;
      else if (arm_set_i)                     state_q <= SEQ_ONE;
      else if (armed_i && trig_i)             state_q <= SEQ_IDLE;
      else if (armed_i && step_i && legal)    state_q <= next_i;
   end

   assign state_o = state_q;

   a_r3_arm_loads_one: assert property (@(posedge clk) disable iff (!por_n)
      (sys_rst_n && arm_set_i) |=> (state_q == SEQ_ONE));
   a_r8_trig_to_idle: assert property (@(posedge clk) disable iff (!por_n)
      (sys_rst_n && !arm_set_i && armed_i && trig_i) |=> (state_q == SEQ_IDLE));
   a_r9_hold: assert property (@(posedge clk) disable iff (!por_n)
      (sys_rst_n && !arm_set_i && !(armed_i && (trig_i || step_i))) |=> $stable(state_q));
   a_r7_never_reserved: assert property (@(posedge clk) disable iff (!por_n)
      state_q <= SEQ_LAST_LEGAL);
endmodule

// File: rtl/dbg_status_tracker.sv
module dbg_status_tracker
   import dst_pkg::*;
#(
   parameter int unsigned TRACE_DEPTH = 64,
   localparam int unsigned CNT_W = $clog2(TRACE_DEPTH) + 1
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                sys_rst_n,
   input  logic                arm_set,
   input  logic                arm_clr,
   input  logic                line_stored,
   input  logic                ext_tag_hit,
   input  logic                seq_step,
   input  logic [SEQ_W-1:0]    seq_state,
   input  logic                trig_end,
   output logic [STATUS_W-1:0] status_word,
   output logic                armed_o,
   output logic [CNT_W-1:0]    valid_lines
);
   generate
      if (STATUS_W <= FULL_BIT || FULL_BIT <= TAG_BIT || TAG_BIT < SEQ_W) begin : g_bad_layout
         $error("dbg_status_tracker: status word layout is inconsistent");
      end
   endgenerate

   logic             armed_q;
   logic             full;
   logic             tag;
   logic [SEQ_W-1:0] st;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                   armed_q <= 1'b0;
      else if (!sys_rst_n)                          armed_q <= 1'b0;
      else if (arm_set)                             armed_q <= 1'b1;
      else if (armed_q && (arm_clr || trig_end))    armed_q <= 1'b0;
   end

   dst_line_counter #(.DEPTH(TRACE_DEPTH)) u_lines (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .arm_set_i(arm_set),
      .armed_i(armed_q), .line_i(line_stored), .full_o(full), .valid_o(valid_lines)
   );

   dst_tag_flag u_tag (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .arm_set_i(arm_set),
      .armed_i(armed_q), .hit_i(ext_tag_hit), .flag_o(tag)
   );

   dst_state_field #(.STATE_W(SEQ_W)) u_state (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .arm_set_i(arm_set),
      .armed_i(armed_q), .step_i(seq_step), .next_i(seq_state),
      .trig_i(trig_end), .state_o(st)
   );

   always_comb begin
      status_word           = '0;
      status_word[FULL_BIT] = full;
      status_word[TAG_BIT]  = tag;
      status_word[SEQ_W-1:0] = st;
   end

   assign armed_o = armed_q;

   a_r3_arm_clears_flags: assert property (@(posedge clk) disable iff (!por_n)
      (sys_rst_n && arm_set) |=> (!status_word[FULL_BIT] && !status_word[TAG_BIT] && armed_o));
   a_r8_trig_disarms: assert property (@(posedge clk) disable iff (!por_n)
      (sys_rst_n && !arm_set && armed_o && trig_end) |=> !armed_o);
   a_r10_valid_full: assert property (@(posedge clk) disable iff (!por_n)
      status_word[FULL_BIT] |-> (valid_lines == CNT_W'(TRACE_DEPTH)));
endmodule

// File: tb/dbg_status_tracker_test.sv
module dbg_status_tracker_test;
   localparam int CLK_P = 10;
   localparam int DEPTH = 64;

   logic clk = 1'b0;
   logic por_n, sys_rst_n, arm_set, arm_clr, line_stored, ext_tag_hit, seq_step, trig_end;
   logic [2:0] seq_state;
   logic [7:0] status_word;
   logic       armed_o;
   logic [6:0] valid_lines;

   int checks = 0;
   int errors = 0;

   // bench model
   logic       m_armed, m_full, m_ext;
   int         m_cnt;
   logic [2:0] m_st;

   always #(CLK_P/2) clk = ~clk;

   dbg_status_tracker uut (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .arm_set(arm_set),
      .arm_clr(arm_clr), .line_stored(line_stored), .ext_tag_hit(ext_tag_hit),
      .seq_step(seq_step), .seq_state(seq_state), .trig_end(trig_end),
      .status_word(status_word), .armed_o(armed_o), .valid_lines(valid_lines)
   );

   function automatic logic [7:0] exp_status();
      return {m_full, m_ext, 3'b000, m_st};
   endfunction

   function automatic int exp_valid();
      return m_full ? DEPTH : m_cnt;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cmp_all();
      chk("R2 full flag", int'(status_word[7]), int'(m_full));
      chk("R5 tag flag", int'(status_word[6]), int'(m_ext));
      chk("R1 reserved bits", int'(status_word[5:3]), 0);
      chk("R7 state field", int'(status_word[2:0]), int'(m_st));
      chk("R10 valid lines", int'(valid_lines), exp_valid());
      chk("R8 armed", int'(armed_o), int'(m_armed));
   endtask

   task automatic model_step();
      logic a;
      a = m_armed;
      if (!sys_rst_n) begin
         m_armed = 0; m_ext = 0; m_cnt = 0; m_st = 3'b000;
      end else if (arm_set) begin
         m_armed = 1; m_ext = 0; m_cnt = 0; m_full = 0; m_st = 3'b001;
      end else begin
         if (a && (arm_clr || trig_end)) m_armed = 0;
         if (a && line_stored && m_cnt < DEPTH) begin
            m_cnt++;
            if (m_cnt == DEPTH) m_full = 1;
         end
         if (a && ext_tag_hit) m_ext = 1;
         if (a && trig_end) m_st = 3'b000;
         else if (a && seq_step && seq_state <= 3'b100) m_st = seq_state;
      end
   endtask

   // called at a falling edge: drive, model, wait one cycle, compare
   task automatic cyc(input logic as, input logic ac, input logic ln, input logic ht,
                      input logic sp, input logic [2:0] si, input logic te, input logic sr);
      arm_set = as; arm_clr = ac; line_stored = ln; ext_tag_hit = ht;
      seq_step = sp; seq_state = si; trig_end = te; sys_rst_n = sr;
      model_step();
      @(negedge clk);
      cmp_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 3'b000, 0, 1);
   endtask

   task automatic por_pulse();
      por_n = 0;
      m_armed = 0; m_full = 0; m_ext = 0; m_cnt = 0; m_st = 0;
      #1;
      cmp_all();
      @(negedge clk);
      por_n = 1;
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h1d5e_0042));
      por_n = 0; sys_rst_n = 1; arm_set = 0; arm_clr = 0; line_stored = 0;
      ext_tag_hit = 0; seq_step = 0; seq_state = 0; trig_end = 0;
      m_armed = 0; m_full = 0; m_ext = 0; m_cnt = 0; m_st = 0;
      @(negedge clk); @(negedge clk);
      cmp_all();                              // R4 reset state
      chk("R4 reset status", int'(status_word), 0);
      por_n = 1;

      // R6: strobes while disarmed
      cyc(0, 0, 1, 1, 1, 3'b011, 0, 1);
      chk("R6 disarmed no change", int'(status_word), 0);
      chk("R6 disarmed no lines", int'(valid_lines), 0);

      // R3: arm with line and hit in same cycle
      cyc(1, 0, 1, 1, 1, 3'b011, 1, 1);
      chk("R3 arm wins status", int'(status_word), 8'h01);
      chk("R3 arm wins count", int'(valid_lines), 0);

      // R2: fill the buffer
      for (int i = 0; i < 63; i++) cyc(0, 0, 1, 0, 0, 3'b000, 0, 1);
      chk("R2 not full at 63", int'(status_word[7]), 0);
      cyc(0, 0, 1, 0, 0, 3'b000, 0, 1);
      chk("R2 full at 64", int'(status_word[7]), 1);
      cyc(0, 0, 1, 0, 0, 3'b000, 0, 1);
      chk("R2 saturated", int'(valid_lines), 64);

      // R7: step to legal, then reserved
      cyc(0, 0, 0, 0, 1, 3'b100, 0, 1);
      chk("R7 final state", int'(status_word[2:0]), 4);
      cyc(0, 0, 0, 0, 1, 3'b110, 0, 1);
      chk("R7 reserved ignored", int'(status_word[2:0]), 4);

      // R5 and R9: hit, then software disarm
      cyc(0, 0, 0, 1, 0, 3'b000, 0, 1);
      cyc(0, 1, 0, 0, 0, 3'b000, 0, 1);
      chk("R9 state kept", int'(status_word[2:0]), 4);
      chk("R5 tag sticky", int'(status_word[6]), 1);

      // R4 and R10: system reset keeps full flag
      cyc(0, 0, 0, 0, 0, 3'b000, 0, 0);
      chk("R4 full kept by sys reset", int'(status_word[7]), 1);
      chk("R10 valid while full", int'(valid_lines), 64);

      // R8: internal trigger end
      cyc(1, 0, 0, 0, 0, 3'b000, 0, 1);
      cyc(0, 0, 0, 0, 1, 3'b011, 0, 1);
      cyc(0, 0, 0, 0, 1, 3'b010, 1, 1);
      chk("R8 trigger to idle", int'(status_word[2:0]), 0);
      chk("R8 trigger disarms", int'(armed_o), 0);

      // R4: power-on reset clears full
      cyc(1, 0, 0, 0, 0, 3'b000, 0, 1);
      for (int i = 0; i < 64; i++) cyc(0, 0, 1, 0, 0, 3'b000, 0, 1);
      por_pulse();
      chk("R4 por clears full", int'(status_word[7]), 0);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         cyc(($urandom % 45) == 0, ($urandom % 70) == 0, ($urandom % 4) != 0,
             ($urandom % 12) == 0, ($urandom % 3) == 0, 3'($urandom % 8),
             ($urandom % 90) == 0, ($urandom % 250) != 0);
      end
      idle(2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule